// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is an eight-pin general-purpose I/O port on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. Software sets each pin as an input or an output, writes output levels and reads pin levels. It also configures per-pin interrupts, selects alternate functions and stores pad-control settings. The pad-control settings are only held as values for the pad ring to use.

The data register takes up the whole bottom kilobyte of the address space. Byte-address bits [9:2] act as a per-pin mask for both reads and writes, so a single pin can be set or read without a read-modify-write. Writes to the data register reach only pins that are configured as outputs. Input pins are sampled into the data register on every clock.

Alternate-function select is guarded by a commit mask. The commit mask can only be changed while a small lock state machine is in its open state. The lock state machine has two states:

- `LK_LOCKED`: the reset state.
- `LK_OPEN`: the unlocked state.

Every write to the lock register causes one of two transitions:

- `KEY_MATCH`: the write data equals the unlock key. The next state is `LK_OPEN`.
- `KEY_MISS`: the write data is any other value. The next state is `LK_LOCKED`.

A lock write is taken from either state. With no lock write, the state holds.

Top module: `gpio_bank`

## Requirements
- R1: Reset leaves the following state:
  - Direction, data, interrupt configuration and alternate-function registers are 0.
  - The lock register reads 1 (locked) and the commit register reads 0xFF.
  - Every pin_out bit is 1 and irq is 0.
- R2: A read at any offset below 0x400 returns the data register ANDed with address bits [9:2]. Bit n of that address field selects pin n. Unselected bits read 0.
- R3: A write below 0x400 changes only data bits that are set in both address bits [9:2] and the direction register. Other data bits hold their value.
- R4: For each pin, pin_out equals the data bit when the direction bit is 1 (output). It equals 1 when the direction bit is 0 (input).
- R5: For each pin whose direction bit is 0, the data register takes the pin_in level at each clock edge. A read of that pin in the following cycle shows the new level.
- R6: Sense register (0x404) bit = 1 selects level mode for that pin. In level mode, the raw status bit (read at 0x414) is 1 exactly while the sampled level equals the event register (0x40C) bit. The bit follows a pin change one clock edge after the pin changes.
- R7: Sense bit = 0 selects edge mode, which latches the raw status bit as follows:
  - When the both-edges register (0x408) bit is 1, either edge sets the latch.
  - Otherwise, event bit 1 selects a rising edge and event bit 0 selects a falling edge.
  - The latch is visible two clock edges after the pin change and stays set after the pin returns to its previous level.
- R8: Writing 1s to the clear register (0x41C) clears the matching edge latches. If a new edge and a clear land in the same cycle, the edge wins. The clear register reads 0.
- R9: The masked status (0x418) equals raw status AND the mask register (0x410). irq is 1 exactly when any masked status bit is 1.
- R10: Lock register (0x520) writes follow the two-state machine:
  - Writing 0x0ACCE551 moves to LK_OPEN, and the lock register then reads 0.
  - Writing any other value moves to LK_LOCKED, and the lock register then reads 1.
- R11: The commit register (0x524) accepts writes only in LK_OPEN. A write to alternate-function select (0x420) changes only the bits that are 1 in the commit register.
- R12: Reads from 0xFD0 to 0xFFC return twelve identification bytes, one per word, from the lowest address upward: 00 00 00 00 61 00 18 01 0D F0 05 B1.
- R13: There are eight 8-bit pad-control registers at word offsets 0x500 to 0x51C, and each reads back what was written. Reads from unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Resolved pin drive values |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker watches the following on every cycle:

- Input pins drive high.
- Output-pin data bits hold when no data write occurs.
- irq never rises without both a mask bit and a raw status bit.
- Each lock write lands in the state its key selects.
- The commit mask and alternate-function bits move only when their guards allow.

The bench scenarios show the behaviour that needs stimulus:

- Exact masked read and write values at chosen addresses.
- Sampling latency of input pins.
- Level and edge interrupt detection for each polarity.
- Set-over-clear priority in one cycle.
- Identification bytes and pad-control read-back.
- The silence of unmapped offsets.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned PAD_N  = 8;

    localparam logic [ADDR_W-1:0] OFF_WIN_END = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_DIR     = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_SENSE   = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_BOTH    = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_EVENT   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_MASK    = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW     = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MIS     = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR     = 12'h41C;
    localparam logic [ADDR_W-1:0] OFF_ALT     = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h520;
    localparam logic [ADDR_W-1:0] OFF_COMMIT  = 12'h524;
    localparam logic [ADDR_W-1:0] OFF_ID_BASE = 12'hFD0;
    localparam logic [6:0]        PAD_PAGE    = 7'h28;

    localparam logic [BUS_W-1:0]  UNLOCK_KEY  = 32'h0ACC_E551;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] v;
        unique case (idx)
            4'd4:    v = 8'h61;
            4'd6:    v = 8'h18;
            4'd7:    v = 8'h01;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'hF0;
            4'd10:   v = 8'h05;
            4'd11:   v = 8'hB1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic             commit_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             locked,
    output logic [PINS-1:0]  commit_q
);

    lock_state_e state_q;
    lock_state_e state_d;
    logic        commit_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs: KEY_MATCH opens, KEY_MISS locks
    always_comb begin
        state_d   = state_q;
        locked    = 1'b1;
        commit_en = 1'b0;
        unique case (state_q)
            LK_LOCKED: begin
                locked = 1'b1;
                if (lock_wr && (wdata == UNLOCK_KEY)) begin
                    state_d = LK_OPEN;
                end
            end
            LK_OPEN: begin
                locked    = 1'b0;
                commit_en = commit_wr;
                if (lock_wr && (wdata != UNLOCK_KEY)) begin
                    state_d = LK_LOCKED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_q <= '1;
        end else if (commit_en) begin
            commit_q <= wdata[PINS-1:0];
        end
    end

endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data #(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] dir_q,
    input  logic            win_wr,
    input  logic [PINS-1:0] win_sel,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] data_q,
    output logic [PINS-1:0] pin_out
);

    logic [PINS-1:0] wr_bits;
    logic [PINS-1:0] data_d;

    always_comb begin
        wr_bits = win_wr ? (win_sel & dir_q) : '0;
        data_d  = (data_q & ~wr_bits) | (wdata & wr_bits);
        // input pins always take the sampled external level
        data_d  = (data_d & dir_q) | (pin_in & ~dir_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign pin_out = (data_q & dir_q) | ~dir_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] sense_q,
    input  logic [PINS-1:0] both_q,
    input  logic [PINS-1:0] event_q,
    input  logic            clr_wr,
    input  logic [PINS-1:0] clr_bits,
    output logic [PINS-1:0] raw_st
);

    logic [PINS-1:0] lvl_q;
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            lvl_q  <= pin_in;
            prev_q <= lvl_q;
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic hit;
        logic lat_q;

        always_comb begin
            if (both_q[i]) begin
                hit = lvl_q[i] ^ prev_q[i];
            end else if (event_q[i]) begin
                hit = lvl_q[i] & ~prev_q[i];
            end else begin
                hit = ~lvl_q[i] & prev_q[i];
            end
        end

        // a new edge takes priority over a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_q <= 1'b0;
            end else if (!sense_q[i] && hit) begin
                lat_q <= 1'b1;
            end else if (clr_wr && clr_bits[i]) begin
                lat_q <= 1'b0;
            end
        end

        assign raw_st[i] = sense_q[i] ? (lvl_q[i] == event_q[i]) : lat_q;
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic              irq
);

    localparam int unsigned WIN_LSB = 2;
    localparam int unsigned PAD_IW  = $clog2(PAD_N);

    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] sense_q;
    logic [PINS-1:0] both_q;
    logic [PINS-1:0] event_q;
    logic [PINS-1:0] mask_q;
    logic [PINS-1:0] afsel_q;
    logic [PINS-1:0] commit_q;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] raw_st;
    logic [PINS-1:0] masked_st;
    logic [PINS-1:0] pad_q [PAD_N];
    logic            locked;

    logic            in_win;
    logic [PINS-1:0] win_sel;
    logic            pad_hit;
    logic [PAD_IW-1:0] pad_idx;
    logic            id_hit;
    logic [3:0]      id_idx;

    assign in_win  = (bus_addr < OFF_WIN_END);
    assign win_sel = bus_addr[WIN_LSB +: PINS];
    assign pad_hit = (bus_addr[ADDR_W-1:5] == PAD_PAGE) && (bus_addr[1:0] == 2'b00);
    assign pad_idx = bus_addr[2 +: PAD_IW];
    assign id_hit  = (bus_addr >= OFF_ID_BASE);
    assign id_idx  = bus_addr[5:2] - 4'd4;

    function automatic logic [BUS_W-1:0] zext(input logic [PINS-1:0] v);
        return {{(BUS_W-PINS){1'b0}}, v};
    endfunction

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            mask_q  <= '0;
            afsel_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFF_DIR:   dir_q   <= bus_wdata[PINS-1:0];
                OFF_SENSE: sense_q <= bus_wdata[PINS-1:0];
                OFF_BOTH:  both_q  <= bus_wdata[PINS-1:0];
                OFF_EVENT: event_q <= bus_wdata[PINS-1:0];
                OFF_MASK:  mask_q  <= bus_wdata[PINS-1:0];
                OFF_ALT:   afsel_q <= (afsel_q & ~commit_q) | (bus_wdata[PINS-1:0] & commit_q);
                default: ;
            endcase
        end
    end

    // Pad-control shadow registers
    for (genvar p = 0; p < PAD_N; p++) begin : g_pad
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pad_q[p] <= '0;
            end else if (bus_wr && pad_hit && (pad_idx == PAD_IW'(p))) begin
                pad_q[p] <= bus_wdata[PINS-1:0];
            end
        end
    end

    gpio_lock_ctrl #(.PINS(PINS)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (bus_wr && (bus_addr == OFF_LOCK)),
        .commit_wr (bus_wr && (bus_addr == OFF_COMMIT)),
        .wdata     (bus_wdata),
        .locked    (locked),
        .commit_q  (commit_q)
    );

    gpio_port_data #(.PINS(PINS)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .win_wr  (bus_wr && in_win),
        .win_sel (win_sel),
        .wdata   (bus_wdata[PINS-1:0]),
        .pin_in  (pin_in),
        .data_q  (data_q),
        .pin_out (pin_out)
    );

    gpio_irq_unit #(.PINS(PINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sense_q  (sense_q),
        .both_q   (both_q),
        .event_q  (event_q),
        .clr_wr   (bus_wr && (bus_addr == OFF_CLR)),
        .clr_bits (bus_wdata[PINS-1:0]),
        .raw_st   (raw_st)
    );

    assign masked_st = raw_st & mask_q;
    assign irq       = |masked_st;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            bus_rdata = zext(data_q & win_sel);
        end else if (id_hit) begin
            bus_rdata = {{(BUS_W-8){1'b0}}, id_byte(id_idx)};
        end else if (pad_hit) begin
            bus_rdata = zext(pad_q[pad_idx]);
        end else begin
            unique case (bus_addr)
                OFF_DIR:    bus_rdata = zext(dir_q);
                OFF_SENSE:  bus_rdata = zext(sense_q);
                OFF_BOTH:   bus_rdata = zext(both_q);
                OFF_EVENT:  bus_rdata = zext(event_q);
                OFF_MASK:   bus_rdata = zext(mask_q);
                OFF_RAW:    bus_rdata = zext(raw_st);
                OFF_MIS:    bus_rdata = zext(masked_st);
                OFF_ALT:    bus_rdata = zext(afsel_q);
                OFF_LOCK:   bus_rdata = {{(BUS_W-1){1'b0}}, locked};
                OFF_COMMIT: bus_rdata = zext(commit_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [PINS-1:0]   pin_out,
    input logic              irq,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   data_q,
    input logic [PINS-1:0]   raw_st,
    input logic [PINS-1:0]   mask_q,
    input logic [PINS-1:0]   afsel_q,
    input logic [PINS-1:0]   commit_q,
    input logic              locked
);

    logic data_wr;
    logic lock_wr;
    assign data_wr = bus_wr && (bus_addr < OFF_WIN_END);
    assign lock_wr = bus_wr && (bus_addr == OFF_LOCK);

    a_r4_inputs_float_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~pin_out) == '0));

    a_r3_output_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> (((data_q ^ $past(data_q)) & dir_q & $past(dir_q)) == '0));

    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_st != '0));

    a_r10_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && (bus_wdata == UNLOCK_KEY)) |=> !locked);

    a_r10_miss_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && (bus_wdata != UNLOCK_KEY)) |=> locked);

    a_r11_commit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_q != $past(commit_q)) |-> !$past(locked));

    a_r11_afsel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .raw_st    (raw_st),
    .mask_q    (mask_q),
    .afsel_q   (afsel_q),
    .commit_q  (commit_q),
    .locked    (locked)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;   // 0 read data, 1 pin_out, 2 irq
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    // Monitor: pops expectations a quarter period after they are issued
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.sel == 0) ? bus_rdata :
                      (it.sel == 1) ? {24'b0, pin_out} : {31'b0, irq};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
    endtask

    task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        sb.push_back('{0, e, tag});
    endtask

    task automatic exp_pins(input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        sb.push_back('{1, {24'b0, e}, tag});
    endtask

    task automatic exp_irq(input logic e, input string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        sb.push_back('{2, {31'b0, e}, tag});
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b0;
        pin_in = v;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_rd(12'h400, 32'h0, "R1 dir");
        exp_rd(12'h3FC, 32'h0, "R1 data");
        exp_rd(12'h420, 32'h0, "R1 afsel");
        exp_rd(12'h520, 32'h1, "R1 lock");
        exp_rd(12'h524, 32'hFF, "R1 commit");
        exp_pins(8'hFF, "R1 pins high");
        exp_irq(1'b0, "R1 irq");

        // R12 identification bytes
        exp_rd(12'hFD0, 32'h00, "R12 id0");
        exp_rd(12'hFE0, 32'h61, "R12 id4");
        exp_rd(12'hFE4, 32'h00, "R12 id5");
        exp_rd(12'hFE8, 32'h18, "R12 id6");
        exp_rd(12'hFEC, 32'h01, "R12 id7");
        exp_rd(12'hFF0, 32'h0D, "R12 id8");
        exp_rd(12'hFF4, 32'hF0, "R12 id9");
        exp_rd(12'hFF8, 32'h05, "R12 id10");
        exp_rd(12'hFFC, 32'hB1, "R12 id11");

        // R3 / R4 masked writes and pin resolution
        wr(12'h400, 32'h0F);
        wr(12'h3FC, 32'hFF);
        exp_pins(8'hFF, "R4 outputs high");
        wr(12'h3FC, 32'h00);
        exp_pins(8'hF0, "R4 outputs low inputs high");
        wr(12'h014, 32'hFF);
        exp_pins(8'hF5, "R3 masked bits 0 2");
        wr(12'h3C0, 32'hFF);
        exp_pins(8'hF5, "R3 input bits not written");
        exp_rd(12'h3FC, 32'h05, "R3 data readback");

        // R2 masked reads
        exp_rd(12'h004, 32'h01, "R2 select bit0");
        exp_rd(12'h008, 32'h00, "R2 select bit1");

        // R5 input sampling
        drive(8'hA0);
        exp_rd(12'h3FC, 32'hA5, "R5 inputs sampled");
        exp_rd(12'h200, 32'h80, "R5 single pin7");

        // R6 level mode on pin 0
        wr(12'h404, 32'h01);
        wr(12'h40C, 32'h01);
        wr(12'h410, 32'h01);
        exp_rd(12'h414, 32'h00, "R6 level low");
        drive(8'hA1);
        exp_rd(12'h414, 32'h01, "R6 level high active");
        exp_irq(1'b1, "R9 irq level");
        wr(12'h40C, 32'h00);
        exp_rd(12'h414, 32'h00, "R6 active low polarity");
        wr(12'h40C, 32'h01);
        wr(12'h410, 32'h00);
        exp_irq(1'b0, "R9 irq masked off");
        exp_rd(12'h414, 32'h01, "R9 raw unaffected by mask");

        // R7 edge modes
        wr(12'h40C, 32'h03);
        drive(8'hA3);
        idle();
        exp_rd(12'h414, 32'h03, "R7 rising latched");
        drive(8'hA1);
        idle();
        exp_rd(12'h414, 32'h03, "R7 latch holds");
        wr(12'h41C, 32'h02);
        exp_rd(12'h414, 32'h01, "R8 clear bit1");
        exp_rd(12'h41C, 32'h00, "R8 clear reads zero");
        drive(8'h21);
        idle();
        exp_rd(12'h414, 32'h81, "R7 falling latched");
        wr(12'h408, 32'h40);
        drive(8'h61);
        idle();
        exp_rd(12'h414, 32'hC1, "R7 both edges rise");
        wr(12'h41C, 32'h40);
        exp_rd(12'h414, 32'h81, "R8 clear bit6");
        drive(8'h21);
        idle();
        exp_rd(12'h414, 32'hC1, "R7 both edges fall");
        wr(12'h41C, 32'hFE);
        exp_rd(12'h414, 32'h01, "R8 clear keeps level bit");

        // R8 edge and clear in the same cycle
        drive(8'h23);
        wr(12'h41C, 32'h02);
        exp_rd(12'h414, 32'h03, "R8 edge wins over clear");
        wr(12'h41C, 32'h02);
        exp_rd(12'h414, 32'h01, "R8 later clear");

        // R9 masked status
        wr(12'h410, 32'h02);
        exp_rd(12'h418, 32'h00, "R9 masked none");
        exp_irq(1'b0, "R9 irq none");
        wr(12'h410, 32'h01);
        exp_rd(12'h418, 32'h01, "R9 masked bit0");
        exp_irq(1'b1, "R9 irq set");

        // R10 / R11 lock, commit, alternate function
        wr(12'h420, 32'hFF);
        exp_rd(12'h420, 32'hFF, "R11 afsel full commit");
        wr(12'h524, 32'h0F);
        exp_rd(12'h524, 32'hFF, "R11 commit ignored locked");
        wr(12'h520, 32'h0ACCE551);
        exp_rd(12'h520, 32'h0, "R10 unlocked");
        wr(12'h524, 32'h0F);
        exp_rd(12'h524, 32'h0F, "R11 commit written open");
        wr(12'h520, 32'h1234);
        exp_rd(12'h520, 32'h1, "R10 relocked");
        wr(12'h420, 32'h00);
        exp_rd(12'h420, 32'hF0, "R11 afsel gated by commit");
        wr(12'h524, 32'h00);
        exp_rd(12'h524, 32'h0F, "R11 commit held locked");

        // R13 pad registers and unmapped space
        wr(12'h50C, 32'h5A);
        wr(12'h51C, 32'h3C);
        exp_rd(12'h50C, 32'h5A, "R13 pad 3");
        exp_rd(12'h51C, 32'h3C, "R13 pad 7");
        exp_rd(12'h500, 32'h00, "R13 pad 0 untouched");
        wr(12'h428, 32'hFF);
        exp_rd(12'h428, 32'h00, "R13 unmapped reads zero");
        exp_rd(12'h400, 32'h0F, "R13 unmapped write ignored");
        exp_rd(12'h600, 32'h00, "R13 unmapped high");

        idle();
        idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule